// File: doc/BRIEF.md
# Three-Channel Complementary PWM with Dead-Time Insertion

This block turns one free-running up-counter into three edge-aligned PWM channels. Each channel drives a pair of pins, a main pin and its complement, that are never active at the same time. Every time a channel's reference waveform changes state, both pins of that pair stay inactive for a programmable number of clock cycles. Only after that gap does the pin that is about to turn on become active. A pulse that would be shorter than this gap is dropped entirely.

The period and the three compare values are taken into working registers only at the wrap of the counter. A new duty cycle therefore never cuts a running period. A fault input, with selectable active level, instantly forces all six pins to programmed idle levels and clears the output-enable flag. Software sets the flag again through a set pulse. When automatic re-enable is selected, the block sets the flag itself at the first wrap after the fault has gone away.

A one-shot lock request freezes the safety-relevant settings until the next reset: the dead time, the fault enable and level, automatic re-enable, and both idle levels. A parameter selects whether the fault input acts asynchronously or through a two-flop synchronizer.

Top module: `cpwm_trio`

## Requirements
- R1: The counter runs 0, 1, …, P and then returns to 0, where P is the active period value. `upd_pulse` is high during exactly the cycle in which the count equals P.
- R2: `cfg_period` and `cfg_cmp` are sampled only on the clock edge that ends an `upd_pulse` cycle. Changes made at any other time have no effect until that edge.
- R3: Channel i's reference is active while count ≥ C_i, where C_i is `cfg_cmp[16*i +: 16]`. With C_i = 0 it is active for the whole period. With C_i > P it is never active.
- R4: While outputs are enabled, each pin equals its activity XOR its polarity bit, where 1 means active-low. `cfg_pol_main` applies to the main pins and `cfg_pol_comp` to the complementary pins. Both act combinationally and are not lockable.
- R5: The pin activity follows the reference through one register stage. When the reference changes, both pins of the pair are inactive for D further cycles, where D is the effective dead time, and only then does the new pin become active. With D = 0 the new pin is active in the very next cycle.
- R6: If the reference changes again before the dead-time gap has elapsed, the gap restarts. The pin that would have turned on stays inactive for that whole stretch.
- R7: When `cfg_brk_en` is 1 and `brk_in` differs from `cfg_brk_pol` (0 means active-high), all main pins show the idle-main level and all complementary pins show the idle-comp level within the same cycle. The output-enable flag is then clear at the next edge.
- R8: `moe_set` sets the output-enable flag at the next edge unless a fault is active. While the flag is clear, the pins hold the idle levels.
- R9: With automatic re-enable on, the flag is set at the edge ending the first `upd_pulse` cycle in which no fault is active. With it off, the flag stays clear until `moe_set`.
- R10: During and after reset the flag is clear, so the main pins are high and the complementary pins are low until the flag is set.
- R11: Unlocked settings take effect one cycle after they are applied. After `lock_req`, the dead time, fault enable, fault level, automatic re-enable and idle levels keep their values until reset. The polarities remain live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | 16 | Period value P, preloaded at wrap |
| cfg_cmp | input | 48 | Three compare values, channel i in bits 16*i+15:16*i |
| cfg_dead | input | 8 | Dead time in clock cycles (lockable) |
| cfg_pol_main | input | 1 | Main pin polarity, 1 = active-low |
| cfg_pol_comp | input | 1 | Complementary pin polarity, 1 = active-low |
| cfg_idle_main | input | 1 | Main pin level while disabled (lockable) |
| cfg_idle_comp | input | 1 | Complementary pin level while disabled (lockable) |
| cfg_brk_en | input | 1 | Fault input enable (lockable) |
| cfg_brk_pol | input | 1 | Fault level, 0 = active-high (lockable) |
| cfg_auto_oe | input | 1 | Automatic re-enable at wrap (lockable) |
| lock_req | input | 1 | Freezes the lockable settings until reset |
| moe_set | input | 1 | Sets the output-enable flag |
| brk_in | input | 1 | Fault input |
| pwm_main | output | 3 | Main pins, one per channel |
| pwm_comp | output | 3 | Complementary pins, one per channel |
| upd_pulse | output | 1 | High in the last cycle of each period |

## Verification
The bench builds the block with its defaults: 16-bit counter, 8-bit dead time, three channels and the asynchronous fault path. A short period of 19 and dead times of 0, 2 and 7 let a few hundred cycles cover many wraps. Compare values of 0, beyond the period and two counts before the wrap reach the full-on, never-on and dropped-sliver cases. The fault input is also toggled between clock edges, so the combinational forcing to idle is observed before any register could react.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;

   // Settings that the lock request freezes
   typedef struct packed {
      logic brk_en;
      logic brk_pol;
      logic auto_oe;
      logic idle_main;
      logic idle_comp;
   } cpwm_lockset_t;

   // Pin level from activity and an active-low flag
   function automatic logic pin_level(input logic act, input logic act_low);
      return act ^ act_low;
   endfunction

endpackage

// File: rtl/cpwm_timebase.sv
`timescale 1ns/1ps
module cpwm_timebase #(
   parameter int CNT_W = 16,
   parameter int NCH   = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [CNT_W-1:0]       period_i,
   input  logic [NCH*CNT_W-1:0]   cmp_i,
   output logic [NCH-1:0]         ref_o,
   output logic                   upd_o
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0]     cnt_q;
   logic [CNT_W-1:0]     per_q;
   logic [NCH*CNT_W-1:0] cmp_q;

   assign upd_o = (cnt_q == per_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         per_q <= '0;
         cmp_q <= '0;
      end else if (upd_o) begin
         cnt_q <= '0;
         per_q <= period_i;
         cmp_q <= cmp_i;
      end else begin
         cnt_q <= cnt_q + CNT_ONE;
      end
   end

   // PWM mode 2: reference active from the compare value to period end
   for (genvar g = 0; g < NCH; g++) begin : g_cmp
      assign ref_o[g] = (cnt_q >= cmp_q[g*CNT_W +: CNT_W]);
   end

   p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= per_q);
   p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |=> (cnt_q == '0));
   p_preload_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_o |=> ($stable(per_q) && $stable(cmp_q)));

endmodule

// File: rtl/cpwm_deadband.sv
`timescale 1ns/1ps
module cpwm_deadband #(
   parameter int DT_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ref_i,
   input  logic [DT_W-1:0] dead_i,
   output logic            main_act_o,
   output logic            comp_act_o
);
   localparam logic [DT_W-1:0] DT_ONE = DT_W'(1);

   logic            ref_q;
   logic [DT_W-1:0] dcnt_q;
   logic            settled;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q  <= 1'b0;
         dcnt_q <= '0;
      end else begin
         ref_q <= ref_i;
         if (ref_i != ref_q) begin
            dcnt_q <= dead_i;
         end else if (dcnt_q != '0) begin
            dcnt_q <= dcnt_q - DT_ONE;
         end
      end
   end

   assign settled    = (dcnt_q == '0);
   assign main_act_o = ref_q & settled;
   assign comp_act_o = ~ref_q & settled;

   // every reference edge opens a gap with both outputs off
   p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((ref_i != ref_q) && (dead_i != '0)) |=> (!main_act_o && !comp_act_o));
   // a restarted gap keeps the newly requested output off
   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((dcnt_q > DT_ONE) && (ref_i == ref_q)) |=> (!main_act_o && !comp_act_o));

endmodule

// File: rtl/cpwm_guard.sv
`timescale 1ns/1ps
module cpwm_guard
   import cpwm_pkg::*;
#(
   parameter int   DT_W          = 8,
   parameter int   SYNC_BRK      = 0,
   parameter logic IDLE_MAIN_RST = 1'b1,
   parameter logic IDLE_COMP_RST = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DT_W-1:0] dead_i,
   input  cpwm_lockset_t   set_i,
   input  logic            lock_req_i,
   input  logic            moe_set_i,
   input  logic            brk_i,
   input  logic            upd_i,
   output logic            gate_o,
   output logic [DT_W-1:0] dead_o,
   output cpwm_lockset_t   set_o
);
   localparam cpwm_lockset_t SET_RST = '{brk_en: 1'b0, brk_pol: 1'b0, auto_oe: 1'b0,
                                         idle_main: IDLE_MAIN_RST, idle_comp: IDLE_COMP_RST};

   logic            locked_q;
   logic [DT_W-1:0] dead_q;
   cpwm_lockset_t   set_q;
   logic            moe_q;
   logic            brk_s;
   logic            brk_act;

   if (SYNC_BRK != 0) begin : g_brk_sync
      logic [1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[0], brk_i};
      end
      assign brk_s = sync_q[1];
   end else begin : g_brk_async
      assign brk_s = brk_i;
   end

   assign brk_act = set_q.brk_en & (brk_s ^ set_q.brk_pol);
   assign gate_o  = moe_q & ~brk_act;
   assign dead_o  = dead_q;
   assign set_o   = set_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         dead_q   <= '0;
         set_q    <= SET_RST;
      end else begin
         if (!locked_q) begin
            dead_q <= dead_i;
            set_q  <= set_i;
         end
         if (lock_req_i) locked_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         moe_q <= 1'b0;
      end else if (brk_act) begin
         moe_q <= 1'b0;
      end else if (moe_set_i || (set_q.auto_oe && upd_i)) begin
         moe_q <= 1'b1;
      end
   end

   p_brk_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      brk_act |=> !moe_q);
   p_manual_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (moe_set_i && !brk_act) |=> moe_q);
   p_auto_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!brk_act && set_q.auto_oe && upd_i) |=> moe_q);
   p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> ($stable(dead_q) && $stable(set_q)));

endmodule

// File: rtl/cpwm_trio.sv
`timescale 1ns/1ps
module cpwm_trio
   import cpwm_pkg::*;
#(
   parameter int   CNT_W         = 16,
   parameter int   NCH           = 3,
   parameter int   DT_W          = 8,
   parameter int   SYNC_BRK      = 0,
   parameter logic IDLE_MAIN_RST = 1'b1,
   parameter logic IDLE_COMP_RST = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CNT_W-1:0]     cfg_period,
   input  logic [NCH*CNT_W-1:0] cfg_cmp,
   input  logic [DT_W-1:0]      cfg_dead,
   input  logic                 cfg_pol_main,
   input  logic                 cfg_pol_comp,
   input  logic                 cfg_idle_main,
   input  logic                 cfg_idle_comp,
   input  logic                 cfg_brk_en,
   input  logic                 cfg_brk_pol,
   input  logic                 cfg_auto_oe,
   input  logic                 lock_req,
   input  logic                 moe_set,
   input  logic                 brk_in,
   output logic [NCH-1:0]       pwm_main,
   output logic [NCH-1:0]       pwm_comp,
   output logic                 upd_pulse
);
   // elaboration-time parameter checks
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("cpwm_trio: CNT_W out of range");
   end
   if (NCH < 1 || NCH > 16) begin : g_bad_nch
      $error("cpwm_trio: NCH out of range");
   end
   if (DT_W < 1 || DT_W > CNT_W) begin : g_bad_dt
      $error("cpwm_trio: DT_W out of range");
   end
   if (SYNC_BRK < 0 || SYNC_BRK > 1) begin : g_bad_sync
      $error("cpwm_trio: SYNC_BRK must be 0 or 1");
   end

   logic [NCH-1:0]  ref_w;
   logic [NCH-1:0]  main_act;
   logic [NCH-1:0]  comp_act;
   logic            gate;
   logic [DT_W-1:0] dead_eff;
   cpwm_lockset_t   set_in;
   cpwm_lockset_t   set_eff;

   assign set_in = '{brk_en: cfg_brk_en, brk_pol: cfg_brk_pol, auto_oe: cfg_auto_oe,
                     idle_main: cfg_idle_main, idle_comp: cfg_idle_comp};

   cpwm_timebase #(.CNT_W(CNT_W), .NCH(NCH)) u_tb (
      .clk      (clk),
      .rst_n    (rst_n),
      .period_i (cfg_period),
      .cmp_i    (cfg_cmp),
      .ref_o    (ref_w),
      .upd_o    (upd_pulse)
   );

   cpwm_guard #(
      .DT_W(DT_W), .SYNC_BRK(SYNC_BRK),
      .IDLE_MAIN_RST(IDLE_MAIN_RST), .IDLE_COMP_RST(IDLE_COMP_RST)
   ) u_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .dead_i     (cfg_dead),
      .set_i      (set_in),
      .lock_req_i (lock_req),
      .moe_set_i  (moe_set),
      .brk_i      (brk_in),
      .upd_i      (upd_pulse),
      .gate_o     (gate),
      .dead_o     (dead_eff),
      .set_o      (set_eff)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      cpwm_deadband #(.DT_W(DT_W)) u_db (
         .clk        (clk),
         .rst_n      (rst_n),
         .ref_i      (ref_w[g]),
         .dead_i     (dead_eff),
         .main_act_o (main_act[g]),
         .comp_act_o (comp_act[g])
      );
      assign pwm_main[g] = gate ? pin_level(main_act[g], cfg_pol_main) : set_eff.idle_main;
      assign pwm_comp[g] = gate ? pin_level(comp_act[g], cfg_pol_comp) : set_eff.idle_comp;
   end

   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !gate |-> ((pwm_main == {NCH{set_eff.idle_main}}) && (pwm_comp == {NCH{set_eff.idle_comp}})));
   p_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      gate |-> ((main_act & comp_act) == '0));

endmodule

// File: tb/cpwm_trio_bench.sv
`timescale 1ns/1ps
module cpwm_trio_bench;

   typedef struct packed {
      logic [2:0] ma;
      logic [2:0] ca;
      logic       moe;
      logic       upd;
      logic       im;
      logic       ic;
      logic       be;
      logic       bp;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_period = '0;
   logic [47:0] cfg_cmp = '0;
   logic [7:0]  cfg_dead = '0;
   logic        cfg_pol_main = 1'b0, cfg_pol_comp = 1'b0;
   logic        cfg_idle_main = 1'b1, cfg_idle_comp = 1'b0;
   logic        cfg_brk_en = 1'b0, cfg_brk_pol = 1'b0, cfg_auto_oe = 1'b0;
   logic        lock_req = 1'b0, moe_set = 1'b0, brk_in = 1'b0;
   logic [2:0]  pwm_main, pwm_comp;
   logic        upd_pulse;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 0;
   string cur_req = "R10";
   exp_t  q[$];

   always #5 clk = ~clk;

   cpwm_trio u_cpwm_trio (
      .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_cmp(cfg_cmp),
      .cfg_dead(cfg_dead), .cfg_pol_main(cfg_pol_main), .cfg_pol_comp(cfg_pol_comp),
      .cfg_idle_main(cfg_idle_main), .cfg_idle_comp(cfg_idle_comp),
      .cfg_brk_en(cfg_brk_en), .cfg_brk_pol(cfg_brk_pol), .cfg_auto_oe(cfg_auto_oe),
      .lock_req(lock_req), .moe_set(moe_set), .brk_in(brk_in),
      .pwm_main(pwm_main), .pwm_comp(pwm_comp), .upd_pulse(upd_pulse)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
      n_chk++;
      if (act !== exp_v) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp_v, $time);
      end
   endtask

   // reference model from the requirements, advanced at every edge
   int m_cnt, m_per, m_dead;
   int m_cmp[3];
   int m_dc[3];
   bit m_refd[3];
   bit m_moe, m_locked, m_be, m_bp, m_auto, m_im, m_ic;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_per = 0; m_dead = 0; m_moe = 0; m_locked = 0;
         m_be = 0; m_bp = 0; m_auto = 0; m_im = 1; m_ic = 0;
         for (int i = 0; i < 3; i++) begin m_cmp[i] = 0; m_dc[i] = 0; m_refd[i] = 0; end
         q.delete();
      end else begin
         automatic bit   upd = (m_cnt == m_per);
         automatic bit   brk = m_be & (brk_in ^ m_bp);
         automatic exp_t e;
         for (int i = 0; i < 3; i++) begin
            automatic bit r = (m_cnt >= m_cmp[i]);
            if (r != m_refd[i]) m_dc[i] = m_dead;
            else if (m_dc[i] > 0) m_dc[i] = m_dc[i] - 1;
            m_refd[i] = r;
         end
         if (upd) begin
            m_cnt = 0;
            m_per = int'(cfg_period);
            for (int i = 0; i < 3; i++) m_cmp[i] = int'(cfg_cmp[i*16 +: 16]);
         end else begin
            m_cnt = m_cnt + 1;
         end
         if (brk) m_moe = 0;
         else if (moe_set || (m_auto && upd)) m_moe = 1;
         if (!m_locked) begin
            m_dead = int'(cfg_dead); m_be = cfg_brk_en; m_bp = cfg_brk_pol;
            m_auto = cfg_auto_oe; m_im = cfg_idle_main; m_ic = cfg_idle_comp;
         end
         if (lock_req) m_locked = 1;
         for (int i = 0; i < 3; i++) begin
            e.ma[i] = m_refd[i] && (m_dc[i] == 0);
            e.ca[i] = !m_refd[i] && (m_dc[i] == 0);
         end
         e.moe = m_moe; e.upd = (m_cnt == m_per);
         e.im = m_im; e.ic = m_ic; e.be = m_be; e.bp = m_bp;
         q.push_back(e);
      end
   end

   // monitor: pops one expected item per cycle, compares mid-cycle
   always @(negedge clk) begin
      if (rst_n && q.size() > 0) begin
         automatic exp_t e = q.pop_front();
         automatic bit   brk = e.be & (brk_in ^ e.bp);
         automatic bit   gate = e.moe & ~brk;
         automatic logic [2:0] em = gate ? (e.ma ^ {3{cfg_pol_main}}) : {3{e.im}};
         automatic logic [2:0] ec = gate ? (e.ca ^ {3{cfg_pol_comp}}) : {3{e.ic}};
         chk({cur_req, " pins"}, {1'b0, upd_pulse, pwm_comp, pwm_main}, {1'b0, e.upd, ec, em});
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wait_upd();
      @(negedge clk);
      while (!upd_pulse) @(negedge clk);
      @(posedge clk);
      #2;
   endtask

   initial begin
      int cnt_on;
      // R10: reset state
      #23;
      chk("R10 reset main", {5'd0, pwm_main}, 8'h07);
      chk("R10 reset comp", {5'd0, pwm_comp}, 8'h00);
      step(2);
      rst_n = 1'b1;
      cfg_period = 16'd19;
      cfg_cmp = {16'd14, 16'd9, 16'd4};
      cfg_dead = 8'd2;
      cfg_pol_main = 1'b1; cfg_pol_comp = 1'b1;
      cfg_brk_en = 1'b1; cfg_auto_oe = 1'b1;
      step(3);
      cur_req = "R10";
      chk("R10 idle before enable", {2'b0, pwm_comp, pwm_main}, 8'h07);
      // R1 R3 R4 R5: run with dead time 2
      cur_req = "R1";
      moe_set = 1'b1; step(1); moe_set = 1'b0;
      step(50);
      // R2: compare change mid-period takes effect only at wrap
      cur_req = "R2";
      step(5);
      cfg_cmp = {16'd18, 16'd25, 16'd0};
      step(30);
      // R3 R6: full-on, never-on, dropped sliver
      cur_req = "R6";
      wait_upd();
      cnt_on = 0;
      repeat (40) begin
         @(negedge clk);
         if (pwm_main[2] == 1'b0) cnt_on++;
      end
      chk("R6 sliver suppressed", cnt_on[7:0], 8'd0);
      cnt_on = 0;
      repeat (40) begin
         @(negedge clk);
         if (pwm_main[1] == 1'b0 || pwm_comp[0] == 1'b0) cnt_on++;
      end
      chk("R3 never-on and full-on", cnt_on[7:0], 8'd0);
      // R4: flip polarity live
      cur_req = "R4";
      step(1);
      cfg_pol_main = 1'b0; cfg_cmp = {16'd14, 16'd9, 16'd4};
      step(30);
      cfg_pol_comp = 1'b0;
      step(30);
      // R5: zero dead time
      cur_req = "R5";
      cfg_dead = 8'd0;
      step(45);
      cfg_dead = 8'd3;
      step(25);
      // R7 R9: fault with automatic re-enable
      cur_req = "R7";
      wait_upd();
      step(3);
      brk_in = 1'b1;
      #1;
      chk("R7 fault forces idle", {2'b0, pwm_comp, pwm_main}, 8'h07);
      step(8);
      cur_req = "R9";
      brk_in = 1'b0;
      @(negedge clk);
      chk("R9 idle until wrap", {2'b0, pwm_comp, pwm_main}, 8'h07);
      step(40);
      // R8: fault without automatic re-enable
      cur_req = "R8";
      cfg_auto_oe = 1'b0;
      step(2);
      brk_in = 1'b1; step(3); brk_in = 1'b0;
      step(30);
      chk("R8 stays disabled", {2'b0, pwm_comp, pwm_main}, 8'h07);
      moe_set = 1'b1; step(1); moe_set = 1'b0;
      step(30);
      // R11: lock, then try to change frozen settings
      cur_req = "R11";
      cfg_auto_oe = 1'b1; cfg_dead = 8'd2;
      step(2);
      lock_req = 1'b1; step(1); lock_req = 1'b0;
      cfg_dead = 8'd7; cfg_idle_main = 1'b0; cfg_idle_comp = 1'b1;
      cfg_brk_en = 1'b0; cfg_auto_oe = 1'b0;
      step(40);
      cfg_pol_main = 1'b1;
      step(5);
      brk_in = 1'b1;
      #1;
      chk("R11 locked idle and fault enable", {2'b0, pwm_comp, pwm_main}, 8'h07);
      step(4);
      brk_in = 1'b0;
      step(50);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule